// File: doc/BRIEF.md
# Rising-Edge Set/Clear Flag

This block holds one state bit that two separate control lines steer. A rising edge on the set line drives the bit high. A rising edge on the clear line drives it low. Both lines are treated as asynchronous to the system clock.

Each line passes through its own synchronizer chain and then a rising-edge detector. The detector turns each edge into a one-cycle pulse, and the pulses feed a two-state machine. The machine's states are `ST_CLEAR` (flag low) and `ST_SET` (flag high). It has these transitions:

- `ST_CLEAR` to `ST_SET` on a set pulse.
- `ST_SET` to `ST_CLEAR` on a clear pulse.
- Each state holds itself when no pulse arrives.
- A pulse that asks for the current value also keeps the state.
- Set and clear pulses in the same cycle go through the coincidence rule chosen by `SIMUL_MODE`:
  - 0 flips the state.
  - 1 moves to `ST_SET`.
  - 2 moves to `ST_CLEAR`.

The machine reacts only to pulses, never to levels. Holding one line high therefore never blocks the other line.

Each input must stay at a level for at least two clock cycles to be seen reliably. During reset the detector history follows the synchronized inputs, so a line that stays high through reset release produces no edge.

Top module: `edge_flag_ctrl`

## Requirements
- R1: A rising edge on `set_in` makes `flag_out` 1, provided `clr_in` does not rise in the same cycle.
- R2: A rising edge on `clr_in` makes `flag_out` 0, provided `set_in` does not rise in the same cycle.
- R3: A falling edge on either input, or a constant level on it, leaves `flag_out` unchanged.
- R4: The last rising edge wins. If `clr_in` rises while `set_in` is held high, the flag goes to 0, and the mirror case holds the same way.
- R5: While one input is held high, every new rising edge on the other input takes effect, each time it occurs.
- R6: When both inputs rise in the same cycle, `SIMUL_MODE` decides the result:
  - 0 inverts the flag.
  - 1 sets it to 1.
  - 2 sets it to 0.
- R7: An active-low synchronous reset drives `flag_out` to 0. An input held high across reset release causes no flag change.
- R8: A change on `flag_out` appears exactly `SYNC_STAGES`+1 clock edges after the input edge is presented. With the default of 2 stages that is 3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_in | input | 1 | Asynchronous set request; its rising edge sets the flag |
| clr_in | input | 1 | Asynchronous clear request; its rising edge clears the flag |
| flag_out | output | 1 | Current flag value |

## Verification
The set edge and the clear edge can both reach the state machine in the same cycle. The bench provokes this by raising both inputs on one negative clock edge. It starts from every earlier level pair and from both flag values.

Three instances, one for each `SIMUL_MODE`, receive the same stimulus. Each instance's result is compared with a bench model that computes the edges from the previous and the new input levels. The same sweep also covers the near-coincident case: one input rises while the other is already held high, and there the newer edge must win.

// File: rtl/edge_flag_pkg.sv
package edge_flag_pkg;
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } flag_state_t;

    localparam int MODE_TOGGLE   = 0;
    localparam int MODE_SET_WINS = 1;
    localparam int MODE_CLR_WINS = 2;
endpackage

// File: rtl/edge_flag_sync.sv
module edge_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Chain runs freely (also during reset) so the history reflects the pin.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) chain[g] <= d_in;
        end else begin : g_next
            always_ff @(posedge clk) chain[g] <= chain[g-1];
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/edge_flag_rise.sv
module edge_flag_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_out
);
    logic prev_q;

    // History tracks the level during reset: a held level yields no edge later.
    always_ff @(posedge clk) prev_q <= level_in;

    assign pulse_out = rst_n & level_in & ~prev_q;

    // R3: a held level fires only once, so a pulse never lasts two cycles
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out)
        else $error("edge pulse held longer than one cycle");
endmodule

// File: rtl/edge_flag_fsm.sv
module edge_flag_fsm
    import edge_flag_pkg::*;
#(
    parameter int SIMUL_MODE = MODE_TOGGLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pls,
    input  logic clr_pls,
    output logic flag_out
);
    flag_state_t state_q, state_d;
    flag_state_t both_from_clear, both_from_set;

    // Coincident-edge policy picked at elaboration time.
    if (SIMUL_MODE == MODE_SET_WINS) begin : g_set_wins
        assign both_from_clear = ST_SET;
        assign both_from_set   = ST_SET;
    end else if (SIMUL_MODE == MODE_CLR_WINS) begin : g_clr_wins
        assign both_from_clear = ST_CLEAR;
        assign both_from_set   = ST_CLEAR;
    end else begin : g_toggle
        assign both_from_clear = ST_SET;
        assign both_from_set   = ST_CLEAR;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (set_pls && clr_pls) state_d = both_from_clear;
                else if (set_pls)       state_d = ST_SET;
            end
            ST_SET: begin
                if (set_pls && clr_pls) state_d = both_from_set;
                else if (clr_pls)       state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_out = (state_q == ST_SET);
    end

    // R1
    set_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pls && !clr_pls) |=> flag_out)
        else $error("set pulse did not raise flag");

    // R2
    clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pls && !set_pls) |=> !flag_out)
        else $error("clear pulse did not lower flag");

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pls && !clr_pls) |=> $stable(flag_out))
        else $error("flag moved without a pulse");

    // R6
    if (SIMUL_MODE == MODE_SET_WINS) begin : g_chk_set
        both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pls && clr_pls) |=> flag_out)
            else $error("coincident edges: set priority violated");
    end else if (SIMUL_MODE == MODE_CLR_WINS) begin : g_chk_clr
        both_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pls && clr_pls) |=> !flag_out)
            else $error("coincident edges: clear priority violated");
    end else begin : g_chk_tog
        both_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pls && clr_pls) |=> (flag_out != $past(flag_out)))
            else $error("coincident edges: toggle violated");
    end

    // R7
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> !flag_out)
        else $error("flag not cleared by reset");
endmodule

// File: rtl/edge_flag_ctrl.sv
module edge_flag_ctrl
    import edge_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SIMUL_MODE  = MODE_TOGGLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    output logic flag_out
);
    logic set_sync, clr_sync;
    logic set_pls, clr_pls;

    edge_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_set (
        .clk(clk), .d_in(set_in), .q_out(set_sync));
    edge_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk(clk), .d_in(clr_in), .q_out(clr_sync));

    edge_flag_rise u_rise_set (
        .clk(clk), .rst_n(rst_n), .level_in(set_sync), .pulse_out(set_pls));
    edge_flag_rise u_rise_clr (
        .clk(clk), .rst_n(rst_n), .level_in(clr_sync), .pulse_out(clr_pls));

    edge_flag_fsm #(.SIMUL_MODE(SIMUL_MODE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .set_pls(set_pls), .clr_pls(clr_pls),
        .flag_out(flag_out));
endmodule

// File: tb/edge_flag_ctrl_tb.sv
module edge_flag_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_in = 1'b0;
    logic clr_in = 1'b0;
    logic flag_tog, flag_sw, flag_cw;

    int total = 0;
    int bad = 0;

    // Model state
    logic prev_s = 1'b0, prev_c = 1'b0;
    logic exp_tog = 1'b0, exp_sw = 1'b0, exp_cw = 1'b0;

    always #4 clk = ~clk;

    edge_flag_ctrl #(.SYNC_STAGES(2), .SIMUL_MODE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_in(set_in), .clr_in(clr_in), .flag_out(flag_tog));
    edge_flag_ctrl #(.SYNC_STAGES(2), .SIMUL_MODE(1)) u_dut_set (
        .clk(clk), .rst_n(rst_n), .set_in(set_in), .clr_in(clr_in), .flag_out(flag_sw));
    edge_flag_ctrl #(.SYNC_STAGES(2), .SIMUL_MODE(2)) u_dut_clr (
        .clk(clk), .rst_n(rst_n), .set_in(set_in), .clr_in(clr_in), .flag_out(flag_cw));

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " mode0"}, flag_tog, exp_tog);
        check({tag, " mode1"}, flag_sw, exp_sw);
        check({tag, " mode2"}, flag_cw, exp_cw);
    endtask

    // Apply a level pair, update model from the computed edges, hold 4 cycles, check.
    task automatic step(input logic s, input logic c);
        logic rs, rc;
        string tag;
        @(negedge clk);
        set_in = s;
        clr_in = c;
        rs = s & ~prev_s;
        rc = c & ~prev_c;
        if (rs && rc) begin
            exp_tog = ~exp_tog; exp_sw = 1'b1; exp_cw = 1'b0; tag = "R6";
        end else if (rs) begin
            exp_tog = 1'b1; exp_sw = 1'b1; exp_cw = 1'b1;
            tag = prev_c ? "R4/R5 set while clr held" : "R1";
        end else if (rc) begin
            exp_tog = 1'b0; exp_sw = 1'b0; exp_cw = 1'b0;
            tag = prev_s ? "R4/R5 clr while set held" : "R2";
        end else begin
            tag = "R3";
        end
        prev_s = s;
        prev_c = c;
        repeat (4) @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R7: reset with set_in held high across release
        set_in = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R7 reset value");
        rst_n = 1'b1;
        prev_s = 1'b1;
        repeat (6) @(negedge clk);
        check_all("R7 no false edge after reset");
        step(1'b0, 1'b0);                 // R3: falling edge ignored

        // R8: latency of exactly three edges
        @(negedge clk);
        set_in = 1'b1;
        prev_s = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R8 before third edge", flag_tog, 1'b0);
        @(negedge clk);
        exp_tog = 1'b1; exp_sw = 1'b1; exp_cw = 1'b1;
        check_all("R8 after third edge");
        step(1'b0, 1'b0);

        // R5: repeated clear edges while set is held high, re-set in between
        step(1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1);
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
        end
        step(1'b0, 1'b0);

        // Sweep every level-pair transition, twice for both flag values
        for (int rep = 0; rep < 2; rep++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    step(a[1], a[0]);
                    step(b[1], b[0]);
                end
            end
        end

        // R6: repeated coincident edges from rest
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0);
            step(1'b1, 1'b1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule